// File: doc/BRIEF.md
# Keyboard Command Decoder with Auto-Repeat

This block sits on the keyboard side of a serial link to a host computer. Each byte the host sends is a complete command. A command can drive one of three indicator LEDs, return the controller to its power-up state, or load one of two 6-bit auto-repeat settings: the wait before the first repeat and the spacing between later repeats. The block never answers a command. In the other direction it turns key events from a matrix scanner into single scancode bytes for the link's transmitter. Bit 7 of a scancode byte marks a release and bits 6:0 carry the key code.

The block times auto-repeat from a timebase tick. It keeps the caps-lock state itself and drives the caps LED. It tells the host about caps lock with a synthetic key-down byte when the lock turns on and a key-up byte when it turns off, the same way a shift key reports its state. The physical release of the caps key is never reported. The serial link runs at 9600 baud, so one byte takes about a millisecond. That is far longer than the gap between events in this block, so its output is a one-cycle strobe with a byte and has no backpressure.

Top module: `kbd_cmd_ctrl`

## Requirements
- R1: A command byte 0x00 to 0x05 sets one LED on the following cycle. Bit 0 is the new level and bits 2:1 pick the LED: 0 is red, 1 is green, 2 is blue.
- R2: Command 0x06 clears all four LEDs and the caps flag, restores the default wait and spacing, and stops auto-repeat. A key event or repeat in the same cycle is discarded, and nothing is sent on the next cycle.
- R3: A command 0b01dddddd loads the wait field with bits 5:0, and a command 0b10rrrrrr loads the spacing field with bits 5:0.
- R4: Command bytes 0x07 to 0x3F and 0xC0 to 0xFF change no LED and no setting.
- R5: A command byte never causes a byte to be sent.
- R6: A key event other than caps lock sends {release, code} on the next cycle, where release is 1 for a key-up and 0 for a key-down.
- R7: Pressing caps lock (code 0x3A) toggles the caps flag and led_caps, and sends 0x3A when the lock turns on and 0xBA when it turns off. Releasing caps lock sends nothing.
- R8: After a non-modifier key is pressed, its key-down byte is sent again on the cycle after the (wait+1)*TICK_SCALE-th tick that follows the press cycle.
- R9: After each repeat, the next one comes (spacing+1)*TICK_SCALE ticks later. A changed field takes effect at the next reload.
- R10: Only the most recently pressed non-modifier key repeats, and releasing that key stops the repeat. Releasing other keys has no effect on it. The modifier keys (0x2A, 0x36, 0x1D, 0x3A) never repeat.
- R11: When a repeat falls due in a cycle that carries a key event, the key event's byte is sent, the repeat is dropped, and the spacing period restarts.
- R12: After reset, all LEDs are off, caps is off, nothing is sent, and the fields hold their defaults.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase pulse for auto-repeat timing |
| key_valid | input | 1 | Key event strobe from the scanner |
| key_code | input | 7 | Key code of the event |
| key_down | input | 1 | 1 for a press, 0 for a release |
| cmd_valid | input | 1 | Received command strobe |
| cmd_byte | input | 8 | Received command byte |
| tx_valid | output | 1 | Scancode byte ready for the transmitter |
| tx_byte | output | 8 | Scancode byte, bit 7 set for release |
| led_red | output | 1 | Red LED drive |
| led_green | output | 1 | Green LED drive |
| led_blue | output | 1 | Blue LED drive |
| led_caps | output | 1 | Caps-lock LED drive |

## Verification
The hardest case to reach is a repeat falling due in exactly the cycle that a different key event arrives, because the due cycle depends on hidden counter state. The bench drives the tick input itself instead of using a free-running timebase. It sets the wait and spacing fields to small values and counts ticks from the press, so that a shift press can be placed on the very tick the repeat falls due. It then checks that the full spacing period restarts. A behavioural reference model checks every cycle of every scenario, including reinitialisation during an active repeat.

// File: rtl/kbd_pkg.sv
package kbd_pkg;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_LED,
    CMD_REINIT,
    CMD_WAIT,
    CMD_SPACE
  } cmd_kind_e;

  typedef struct packed {
    cmd_kind_e   kind;
    logic [1:0]  led_sel;
    logic        led_val;
    logic [5:0]  field;
  } cmd_t;

  // Unpack one host command byte.
  function automatic cmd_t decode_cmd(input logic [7:0] b);
    cmd_t c;
    c.kind    = CMD_NONE;
    c.led_sel = b[2:1];
    c.led_val = b[0];
    c.field   = b[5:0];
    if (b[7:6] == 2'b01)      c.kind = CMD_WAIT;
    else if (b[7:6] == 2'b10) c.kind = CMD_SPACE;
    else if (b == 8'h06)      c.kind = CMD_REINIT;
    else if (b < 8'h06)       c.kind = CMD_LED;
    return c;
  endfunction

  // Number of ticks a 6-bit setting stands for.
  function automatic int unsigned period_ticks(input logic [5:0] f,
                                               input int unsigned scale);
    return (int'(f) + 1) * scale;
  endfunction

endpackage

// File: rtl/kbd_cmd_regs.sv
module kbd_cmd_regs
  import kbd_pkg::*;
#(
  parameter int         NUM_LED   = 3,
  parameter logic [5:0] DEF_WAIT  = 6'd32,
  parameter logic [5:0] DEF_SPACE = 6'd8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [7:0]         cmd_byte,
  output logic [NUM_LED-1:0] leds,
  output logic [5:0]         wait_q,
  output logic [5:0]         space_q,
  output logic               reinit
);
  cmd_t cmd;
  assign cmd    = decode_cmd(cmd_byte);
  assign reinit = cmd_valid && (cmd.kind == CMD_REINIT);

  for (genvar i = 0; i < NUM_LED; i++) begin : g_led
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        leds[i] <= 1'b0;
      else if (reinit)
        leds[i] <= 1'b0;
      else if (cmd_valid && cmd.kind == CMD_LED && int'(cmd.led_sel) == i)
        leds[i] <= cmd.led_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q  <= DEF_WAIT;
      space_q <= DEF_SPACE;
    end else if (reinit) begin
      wait_q  <= DEF_WAIT;
      space_q <= DEF_SPACE;
    end else if (cmd_valid) begin
      if (cmd.kind == CMD_WAIT)  wait_q  <= cmd.field;
      if (cmd.kind == CMD_SPACE) space_q <= cmd.field;
    end
  end
endmodule

// File: rtl/kbd_typematic.sv
module kbd_typematic
  import kbd_pkg::*;
#(
  parameter int TICK_SCALE = 8,
  localparam int CNT_W = $clog2(64 * TICK_SCALE + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       reinit,
  input  logic       start,
  input  logic       stop,
  input  logic [5:0] wait_f,
  input  logic [5:0] space_f,
  output logic       fire,
  output logic       active
);
  logic [CNT_W-1:0] left_q;

  assign fire = active && tick && (left_q == CNT_W'(1)) && !start && !stop && !reinit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      left_q <= '0;
    end else if (reinit) begin
      active <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      left_q <= CNT_W'(period_ticks(wait_f, TICK_SCALE));
    end else if (stop) begin
      active <= 1'b0;
    end else if (active && tick) begin
      if (left_q == CNT_W'(1))
        left_q <= CNT_W'(period_ticks(space_f, TICK_SCALE));
      else
        left_q <= left_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/kbd_key_event.sv
module kbd_key_event #(
  parameter int         CODE_W    = 7,
  parameter logic [6:0] CAPS_CODE = 7'h3A,
  parameter logic [6:0] LSH_CODE  = 7'h2A,
  parameter logic [6:0] RSH_CODE  = 7'h36,
  parameter logic [6:0] CTL_CODE  = 7'h1D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_valid,
  input  logic [CODE_W-1:0] key_code,
  input  logic              key_down,
  input  logic              reinit,
  input  logic              rpt_fire,
  output logic              tx_valid,
  output logic [CODE_W:0]   tx_byte,
  output logic              caps_on,
  output logic              caps_toggle,
  output logic              rpt_start,
  output logic              rpt_stop
);
  logic              is_caps, is_mod;
  logic [CODE_W-1:0] rpt_code_q;
  logic              nxt_valid;
  logic [CODE_W:0]   nxt_byte;

  assign is_caps     = (key_code == CAPS_CODE);
  assign is_mod      = is_caps || key_code == LSH_CODE || key_code == RSH_CODE ||
                       key_code == CTL_CODE;
  assign caps_toggle = key_valid && key_down && is_caps && !reinit;
  assign rpt_start   = key_valid && key_down && !is_mod && !reinit;
  assign rpt_stop    = key_valid && !key_down && (key_code == rpt_code_q) && !reinit;

  always_comb begin
    nxt_valid = 1'b0;
    nxt_byte  = '0;
    if (reinit) begin
      nxt_valid = 1'b0;
    end else if (key_valid) begin
      if (is_caps) begin
        nxt_valid = key_down;
        nxt_byte  = {caps_on, key_code};
      end else begin
        nxt_valid = 1'b1;
        nxt_byte  = {!key_down, key_code};
      end
    end else if (rpt_fire) begin
      nxt_valid = 1'b1;
      nxt_byte  = {1'b0, rpt_code_q};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid   <= 1'b0;
      tx_byte    <= '0;
      caps_on    <= 1'b0;
      rpt_code_q <= '0;
    end else begin
      tx_valid <= nxt_valid;
      if (nxt_valid) tx_byte <= nxt_byte;
      if (reinit)           caps_on <= 1'b0;
      else if (caps_toggle) caps_on <= !caps_on;
      if (rpt_start) rpt_code_q <= key_code;
    end
  end
endmodule

// File: rtl/kbd_cmd_ctrl.sv
module kbd_cmd_ctrl #(
  parameter int         TICK_SCALE = 8,
  parameter logic [5:0] DEF_WAIT   = 6'd32,
  parameter logic [5:0] DEF_SPACE  = 6'd8,
  parameter logic [6:0] CAPS_CODE  = 7'h3A,
  parameter logic [6:0] LSH_CODE   = 7'h2A,
  parameter logic [6:0] RSH_CODE   = 7'h36,
  parameter logic [6:0] CTL_CODE   = 7'h1D
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       key_valid,
  input  logic [6:0] key_code,
  input  logic       key_down,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  output logic       tx_valid,
  output logic [7:0] tx_byte,
  output logic       led_red,
  output logic       led_green,
  output logic       led_blue,
  output logic       led_caps
);
  localparam int NUM_LED = 3;
  localparam int CODE_W  = 7;

  logic [NUM_LED-1:0] leds;
  logic [5:0]         wait_q, space_q;
  logic               cmd_reinit;
  logic               rpt_fire, rpt_active, rpt_start, rpt_stop;
  logic               caps_toggle;

  kbd_cmd_regs #(
    .NUM_LED(NUM_LED), .DEF_WAIT(DEF_WAIT), .DEF_SPACE(DEF_SPACE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .leds(leds), .wait_q(wait_q), .space_q(space_q), .reinit(cmd_reinit)
  );

  kbd_typematic #(.TICK_SCALE(TICK_SCALE)) u_rpt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reinit(cmd_reinit),
    .start(rpt_start), .stop(rpt_stop), .wait_f(wait_q), .space_f(space_q),
    .fire(rpt_fire), .active(rpt_active)
  );

  kbd_key_event #(
    .CODE_W(CODE_W), .CAPS_CODE(CAPS_CODE), .LSH_CODE(LSH_CODE),
    .RSH_CODE(RSH_CODE), .CTL_CODE(CTL_CODE)
  ) u_evt (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
    .key_down(key_down), .reinit(cmd_reinit), .rpt_fire(rpt_fire),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .caps_on(led_caps),
    .caps_toggle(caps_toggle), .rpt_start(rpt_start), .rpt_stop(rpt_stop)
  );

  assign led_red   = leds[0];
  assign led_green = leds[1];
  assign led_blue  = leds[2];
endmodule

// File: rtl/kbd_cmd_ctrl_chk.sv
module kbd_cmd_ctrl_chk #(
  parameter logic [6:0] CAPS_CODE = 7'h3A
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       key_valid,
  input logic [6:0] key_code,
  input logic       key_down,
  input logic       cmd_valid,
  input logic [7:0] cmd_byte,
  input logic       tx_valid,
  input logic [7:0] tx_byte,
  input logic       led_red,
  input logic       led_green,
  input logic       led_blue,
  input logic       led_caps,
  input logic       rpt_fire,
  input logic       cmd_reinit
);
  logic [2:0] leds;
  logic       ignored_cmd;
  assign leds        = {led_blue, led_green, led_red};
  assign ignored_cmd = cmd_valid && ((cmd_byte >= 8'h07 && cmd_byte <= 8'h3F) ||
                                     cmd_byte >= 8'hC0);

  assert_led_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_byte < 8'h06 |=> leds[$past(cmd_byte[2:1])] == $past(cmd_byte[0]));

  assert_reinit_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_byte == 8'h06 |=>
      !led_red && !led_green && !led_blue && !led_caps && !tx_valid);

  assert_ignored_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ignored_cmd |=> $stable(leds));

  assert_no_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !key_valid && !tick |=> !tx_valid);

  assert_key_echo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid && key_code != CAPS_CODE && !cmd_reinit |=>
      tx_valid && tx_byte == {!$past(key_down), $past(key_code)});

  assert_caps_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid && key_down && key_code == CAPS_CODE && !cmd_reinit |=>
      led_caps != $past(led_caps));

  assert_caps_release_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid && !key_down && key_code == CAPS_CODE |=> !tx_valid);

  assert_repeat_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !$past(key_valid) |-> $past(tick) && $past(rpt_fire));

  assert_key_priority_R11: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid && key_down && rpt_fire |=> tx_valid && tx_byte[6:0] == $past(key_code));
endmodule

bind kbd_cmd_ctrl kbd_cmd_ctrl_chk #(.CAPS_CODE(CAPS_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .key_valid(key_valid),
  .key_code(key_code), .key_down(key_down), .cmd_valid(cmd_valid),
  .cmd_byte(cmd_byte), .tx_valid(tx_valid), .tx_byte(tx_byte),
  .led_red(led_red), .led_green(led_green), .led_blue(led_blue),
  .led_caps(led_caps), .rpt_fire(rpt_fire), .cmd_reinit(cmd_reinit)
);

// File: tb/tb_kbd_cmd_ctrl.sv
module tb_kbd_cmd_ctrl;
  localparam int         S    = 2;
  localparam logic [5:0] DW   = 6'd3;
  localparam logic [5:0] DS   = 6'd1;
  localparam logic [6:0] CAPS = 7'h3A;
  localparam logic [6:0] LSH  = 7'h2A;
  localparam logic [6:0] RSH  = 7'h36;
  localparam logic [6:0] CTL  = 7'h1D;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0, tick = 1'b0, key_valid = 1'b0, key_down = 1'b0, cmd_valid = 1'b0;
  logic [6:0] key_code = '0;
  logic [7:0] cmd_byte = '0;
  logic       tx_valid, led_red, led_green, led_blue, led_caps;
  logic [7:0] tx_byte;

  kbd_cmd_ctrl #(.TICK_SCALE(S), .DEF_WAIT(DW), .DEF_SPACE(DS)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .key_valid(key_valid),
    .key_code(key_code), .key_down(key_down), .cmd_valid(cmd_valid),
    .cmd_byte(cmd_byte), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .led_red(led_red), .led_green(led_green), .led_blue(led_blue),
    .led_caps(led_caps)
  );

  int    checks = 0, errors = 0;
  string cur_req = "R12";
  bit    done = 0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model.
  int   m_wait, m_space, m_left, m_code;
  bit   m_on, m_caps, m_txv;
  bit   m_led [3];
  int   m_txb;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wait = DW; m_space = DS; m_on = 0; m_caps = 0; m_txv = 0; m_txb = 0;
      m_left = 0; m_code = 0;
      foreach (m_led[i]) m_led[i] = 0;
    end else if (cmd_valid && cmd_byte == 8'h06) begin
      m_wait = DW; m_space = DS; m_on = 0; m_caps = 0; m_txv = 0;
      foreach (m_led[i]) m_led[i] = 0;
    end else begin
      bit is_mod, due;
      is_mod = key_code inside {CAPS, LSH, RSH, CTL};
      due = 0;
      m_txv = 0;
      if (key_valid && key_down && !is_mod) begin
        m_on = 1; m_code = key_code; m_left = (m_wait + 1) * S;
      end else if (key_valid && !key_down && key_code == m_code[6:0] && m_on) begin
        m_on = 0;
      end else if (m_on && tick) begin
        if (m_left == 1) begin due = 1; m_left = (m_space + 1) * S; end
        else m_left--;
      end
      if (key_valid) begin
        if (key_code == CAPS) begin
          if (key_down) begin
            m_txv = 1; m_txb = m_caps ? 8'hBA : 8'h3A; m_caps = !m_caps;
          end
        end else begin
          m_txv = 1; m_txb = key_down ? int'(key_code) : int'(key_code) + 128;
        end
      end else if (due) begin
        m_txv = 1; m_txb = m_code;
      end
      if (cmd_valid) begin
        if (cmd_byte < 8'h06) m_led[cmd_byte >> 1] = cmd_byte[0];
        else if (cmd_byte >= 8'h40 && cmd_byte < 8'h80) m_wait = cmd_byte - 8'h40;
        else if (cmd_byte >= 8'h80 && cmd_byte < 8'hC0) m_space = cmd_byte - 8'h80;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, "tx_valid", tx_valid, m_txv);
      if (m_txv) check(cur_req, "tx_byte", tx_byte, m_txb);
      check(cur_req, "leds", {led_caps, led_blue, led_green, led_red},
            {m_caps, m_led[2], m_led[1], m_led[0]});
    end
  end

  task automatic drive(input bit kv, input logic [6:0] kc, input bit kd,
                       input bit cv, input logic [7:0] cb, input bit tk);
    @(negedge clk);
    key_valid = kv; key_code = kc; key_down = kd;
    cmd_valid = cv; cmd_byte = cb; tick = tk;
    @(negedge clk);
    key_valid = 0; cmd_valid = 0; tick = 0;
  endtask

  task automatic cmd(input logic [7:0] b);   drive(0, '0, 0, 1, b, 0); endtask
  task automatic press(input logic [6:0] c); drive(1, c, 1, 0, '0, 0); endtask
  task automatic rel(input logic [6:0] c);   drive(1, c, 0, 0, '0, 0); endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) drive(0, '0, 0, 0, '0, 1);
  endtask

  task automatic summary();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R12";
    check("R12", "reset outputs", {tx_valid, led_caps, led_blue, led_green, led_red}, 0);

    cur_req = "R1";
    cmd(8'h01); cmd(8'h03); cmd(8'h05);
    check("R1", "all LEDs on", {led_blue, led_green, led_red}, 3'b111);
    cmd(8'h02);
    check("R1", "green off", {led_blue, led_green, led_red}, 3'b101);

    cur_req = "R4";
    cmd(8'h07); cmd(8'h3F); cmd(8'hC0); cmd(8'hFF); cmd(8'h20);
    check("R4", "LEDs after ignored codes", {led_blue, led_green, led_red}, 3'b101);

    cur_req = "R5";
    cmd(8'h04);
    check("R5", "no byte for command", tx_valid, 0);

    cur_req = "R6";
    press(7'h10);
    check("R6", "key down byte", tx_byte, 8'h10);
    rel(7'h10);
    check("R6", "key up byte", tx_byte, 8'h90);
    press(LSH); rel(LSH);

    cur_req = "R7";
    press(CAPS);
    check("R7", "caps on byte", tx_byte, 8'h3A);
    check("R7", "caps led on", led_caps, 1);
    rel(CAPS);
    check("R7", "caps release silent", tx_valid, 0);
    press(CAPS);
    check("R7", "caps off byte", tx_byte, 8'hBA);
    check("R7", "caps led off", led_caps, 0);
    rel(CAPS);

    cur_req = "R3";
    cmd(8'h41); cmd(8'h80);
    cur_req = "R8";
    press(7'h1E);
    ticks(3);
    check("R8", "no repeat before wait", tx_valid, 0);
    ticks(1);
    check("R8", "first repeat", {tx_valid, tx_byte}, {1'b1, 8'h1E});
    cur_req = "R9";
    ticks(1);
    check("R9", "mid spacing silent", tx_valid, 0);
    ticks(1);
    check("R9", "second repeat", {tx_valid, tx_byte}, {1'b1, 8'h1E});
    cmd(8'h82);
    ticks(12);

    cur_req = "R10";
    press(7'h20); ticks(5); rel(7'h1E); ticks(6);
    press(LSH); ticks(6); rel(LSH);
    rel(7'h20);
    ticks(10);
    check("R10", "repeat stopped", tx_valid, 0);
    press(CTL); ticks(8); rel(CTL);

    cur_req = "R11";
    cmd(8'h80);
    press(7'h1E);
    ticks(3);
    drive(1, LSH, 1, 0, '0, 1);
    check("R11", "key wins due cycle", tx_byte, 8'h2A);
    ticks(1);
    check("R11", "spacing restarted", tx_valid, 0);
    ticks(1);
    check("R11", "repeat after restart", {tx_valid, tx_byte}, {1'b1, 8'h1E});
    rel(LSH);

    cur_req = "R2";
    cmd(8'h01); press(CAPS);
    cmd(8'h06);
    check("R2", "LEDs cleared", {led_caps, led_blue, led_green, led_red}, 0);
    ticks(20);
    check("R2", "repeat halted", tx_valid, 0);
    press(7'h1E);
    ticks(4);
    check("R2", "default wait not elapsed", tx_valid, 0);
    ticks(4);
    check("R2", "default wait repeat", {tx_valid, tx_byte}, {1'b1, 8'h1E});
    drive(1, 7'h11, 1, 1, 8'h06, 1);
    check("R2", "key dropped on reinit", tx_valid, 0);
    ticks(20);
    check("R2", "no repeat after reinit", tx_valid, 0);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule